// File: doc/BRIEF.md
# Packed Enable/Status Interrupt Combiner

This block merges a small group of peripheral event lines into one level-sensitive interrupt request for a parent interrupt controller. Each event line has an enable bit and a latched status bit, and all of them live in one 32-bit register. The enable bits sit in the lower half and each status bit sits exactly 16 positions above its enable bit. Software reads the register to see which sources fired, and writes 1 to a status bit to clear it. Writing 0 to a status bit has no effect, so software can update enables by writing zeros in the upper half.

Each source has its own capture state machine. The state machine has two states. `SLOT_IDLE` means the status is clear and `SLOT_LATCHED` means the status is set. It moves between them on three transitions:

- **capture**: IDLE to LATCHED, on a rising edge of the event line.
- **acknowledge**: LATCHED to IDLE, on a write-1 clear with no new rising edge in the same cycle.
- **recapture**: LATCHED stays LATCHED when a rising edge and a clear arrive together.

The output combiner is also a two-state machine. `IRQ_QUIET` moves to `IRQ_RAISED` on the **raise** transition, when any enabled source has its status set. `IRQ_RAISED` returns to `IRQ_QUIET` on the **drop** transition, once no enabled source is pending. Because the combiner is registered, the request follows the pending set one clock later.

Two build-time parameters set the number of sources (`NUM_SRC`) and the enable-bit position of the first source (`FIRST_BIT`). The supported configurations are:

- 7 sources starting at bit 0
- 6 sources starting at bit 0
- 2 sources starting at bit 4

Top module: `evt_irq_combiner`

## Requirements
- R1: Source i has its enable bit at register bit FIRST_BIT+i and its status bit at register bit 16+FIRST_BIT+i. `reg_rdata` always shows the live enable and status bits, and every other bit reads 0.
- R2: A status bit becomes 1 at the first clock edge where its `evt_in` line is 1 after being 0 at the previous edge. This happens whether or not the source is enabled.
- R3: A register write with 1 in a source's status bit clears that status bit. A write with 0 there leaves the status bit unchanged.
- R4: A register write loads every configured enable bit from the matching low-half bit of `reg_wdata`. Bits outside the configured enable and status positions are ignored.
- R5: `irq_out` is 1 exactly one clock after at least one source has both its status and enable bits set, including when an already-latched source is enabled afterwards.
- R6: `irq_out` stays 1 until every enabled pending status bit has been cleared. Clearing only some of them does not drop the request.
- R7: If a rising edge on an event line and a write-1 clear reach the same status bit in the same cycle, the status bit ends up 1.
- R8: While `rst_n` is 0, all enable and status bits are 0 and `irq_out` is 0. This holds when reset is applied in the middle of operation too.
- R9: After a write of 0xFFFF0000 followed by a write of 0x00000000, the register reads 0 and `irq_out` is 0.
- R10: An event line held at 1 sets its status only once. After that status is cleared, it stays 0 until the line falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_SRC | Peripheral event lines, one per source |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data (enables low, write-1-to-clear status high) |
| reg_rdata | output | 32 | Live register contents |
| irq_out | output | 1 | Combined level interrupt to the parent |

## Verification
The main function is driven with the following patterns:

- **Single events on enabled and disabled lines.** These separate capture from gating.
- **An enable written after the status has already latched.** This shows the output responds to enable as well as to events.
- **Several lines pending at once, cleared one at a time.** This tells a level output apart from one that drops on the first acknowledge.
- **A clear colliding with a fresh edge.** This shows which of the two wins.
- **A line held high through its own clear.** This distinguishes edge capture from level capture.
- **Writes with stray bits set outside the configured range.** These show that such bits change nothing.

A second instance with two sources at bit 4 confirms that the bit placement follows the parameters.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    // Register geometry: enables in the low half, status in the high half
    localparam int REG_W  = 32;
    localparam int HALF_W = 16;

    // Per-source capture state
    typedef enum logic {
        SLOT_IDLE    = 1'b0,
        SLOT_LATCHED = 1'b1
    } slot_state_e;

    // Combined request state
    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/evt_irq_slot.sv
module evt_irq_slot
    import evt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic status_o
);

    logic        evt_q;
    logic        rise;
    slot_state_e state_q;
    slot_state_e state_d;

    // Edge detector on the event line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= evt_i;
        end
    end

    assign rise = evt_i & ~evt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: capture, acknowledge, recapture
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: begin
                if (rise) begin
                    state_d = SLOT_LATCHED;
                end
            end
            SLOT_LATCHED: begin
                if (clr_i && !rise) begin
                    state_d = SLOT_IDLE;
                end
            end
            default: state_d = SLOT_IDLE;
        endcase
    end

    // Output
    always_comb begin
        status_o = (state_q == SLOT_LATCHED);
    end

    // R2
    capture_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> status_o);

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !rise) |=> !status_o);

    // R3
    zero_write_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !rise) |=> (status_o == $past(status_o)));

    // R7
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && rise) |=> status_o);

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
    import evt_irq_pkg::*;
#(
    parameter int NUM_SRC   = 7,
    parameter int FIRST_BIT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wen_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [NUM_SRC-1:0] status_i,
    output logic [NUM_SRC-1:0] enable_o,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [REG_W-1:0]   rdata_o
);

    localparam int ST_BASE = HALF_W + FIRST_BIT;
    localparam logic [REG_W-1:0] SRC_ONES = (REG_W'(1) << NUM_SRC) - REG_W'(1);
    localparam logic [REG_W-1:0] LIVE_MASK =
        (SRC_ONES << FIRST_BIT) | (SRC_ONES << ST_BASE);

    logic [NUM_SRC-1:0] en_q;
    logic               unused_wdata_bits;

    // Enable field: loaded on every write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wen_i) begin
            en_q <= wdata_i[FIRST_BIT +: NUM_SRC];
        end
    end

    // Write-1-to-clear strobes for the status field
    always_comb begin
        clr_o = wen_i ? wdata_i[ST_BASE +: NUM_SRC] : '0;
    end

    // Read path: live enable and status, zero elsewhere
    always_comb begin
        rdata_o = '0;
        rdata_o[FIRST_BIT +: NUM_SRC] = en_q;
        rdata_o[ST_BASE +: NUM_SRC]   = status_i;
    end

    assign enable_o          = en_q;
    assign unused_wdata_bits = ^(wdata_i & ~LIVE_MASK);

    // R4
    enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wen_i |=> (enable_o == $past(wdata_i[FIRST_BIT +: NUM_SRC])));

    // R1
    always_ff @(posedge clk) begin
        if (rst_n) begin
            unused_read_zero_chk: assert ((rdata_o & ~LIVE_MASK) == '0);
        end
    end

endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge
    import evt_irq_pkg::*;
#(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] enable_i,
    output logic               irq_o
);

    logic       any_pending;
    irq_state_e state_q;
    irq_state_e state_d;

    assign any_pending = |(status_i & enable_i);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: raise, drop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (any_pending) begin
                    state_d = IRQ_RAISED;
                end
            end
            IRQ_RAISED: begin
                if (!any_pending) begin
                    state_d = IRQ_QUIET;
                end
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    // Output
    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

    // R5
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_pending |=> irq_o);

    // R6
    irq_drops_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(!any_pending));

endmodule

// File: rtl/evt_irq_combiner.sv
module evt_irq_combiner
    import evt_irq_pkg::*;
#(
    parameter int NUM_SRC   = 7,
    parameter int FIRST_BIT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic               reg_wen,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_out
);

    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] clr;

    evt_irq_regs #(
        .NUM_SRC   (NUM_SRC),
        .FIRST_BIT (FIRST_BIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen_i    (reg_wen),
        .wdata_i  (reg_wdata),
        .status_i (status),
        .enable_o (enable),
        .clr_o    (clr),
        .rdata_o  (reg_rdata)
    );

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_slot
        evt_irq_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_in[gi]),
            .clr_i    (clr[gi]),
            .status_o (status[gi])
        );
    end

    evt_irq_merge #(
        .NUM_SRC (NUM_SRC)
    ) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .enable_i (enable),
        .irq_o    (irq_out)
    );

    // R8
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (reg_rdata == '0 && !irq_out);
        end
    end

endmodule

// File: tb/evt_irq_combiner_bench.sv
module evt_irq_combiner_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt = '0;
    logic        wen = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    logic [1:0]  alt_evt = '0;
    logic        alt_wen = 1'b0;
    logic [31:0] alt_wdata = '0;
    logic [31:0] alt_rdata;
    logic        alt_irq;

    int applied = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evt_irq_combiner u_evt_irq_combiner (
        .clk (clk), .rst_n (rst_n), .evt_in (evt), .reg_wen (wen),
        .reg_wdata (wdata), .reg_rdata (rdata), .irq_out (irq)
    );

    evt_irq_combiner #(.NUM_SRC(2), .FIRST_BIT(4)) u_evt_irq_combiner_alt (
        .clk (clk), .rst_n (rst_n), .evt_in (alt_evt), .reg_wen (alt_wen),
        .reg_wdata (alt_wdata), .reg_rdata (alt_rdata), .irq_out (alt_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] data;
        logic [6:0]  ev;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    // exp_rd is read after the edge; exp_irq reflects pending before that edge
    localparam vec_t VECS [15] = '{
        '{1'b1, 32'h0000_0005, 7'h00, 32'h0000_0005, 1'b0, 4'd4},  // R4 enable 0 and 2
        '{1'b0, 32'h0, 7'h01, 32'h0001_0005, 1'b0, 4'd2},           // R2 capture src0
        '{1'b0, 32'h0, 7'h01, 32'h0001_0005, 1'b1, 4'd5},           // R5 request one clock later
        '{1'b0, 32'h0, 7'h02, 32'h0003_0005, 1'b1, 4'd2},           // R2 disabled src1 still latches
        '{1'b1, 32'h0001_0005, 7'h02, 32'h0002_0005, 1'b1, 4'd3},   // R3 clear src0 only
        '{1'b0, 32'h0, 7'h02, 32'h0002_0005, 1'b0, 4'd5},           // R5 src1 not enabled
        '{1'b1, 32'h0000_0007, 7'h00, 32'h0002_0007, 1'b0, 4'd3},   // R3 zero write keeps status
        '{1'b0, 32'h0, 7'h00, 32'h0002_0007, 1'b1, 4'd5},           // R5 late enable raises
        '{1'b1, 32'h0002_FF87, 7'h00, 32'h0000_0007, 1'b1, 4'd4},   // R4 stray bits ignored
        '{1'b0, 32'h0, 7'h00, 32'h0000_0007, 1'b0, 4'd6},           // R6 drops after last clear
        '{1'b1, 32'h0040_007F, 7'h40, 32'h0040_007F, 1'b0, 4'd7},   // R7 edge beats clear
        '{1'b0, 32'h0, 7'h40, 32'h0040_007F, 1'b1, 4'd7},           // R7 still pending
        '{1'b1, 32'h0000_0000, 7'h40, 32'h0040_0000, 1'b1, 4'd1},   // R1 status visible, no enables
        '{1'b0, 32'h0, 7'h00, 32'h0040_0000, 1'b0, 4'd5},           // R5 disabled means quiet
        '{1'b1, 32'hFFFF_0000, 7'h00, 32'h0000_0000, 1'b0, 4'd9}    // R9 clear-all step
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired (all requirements): actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8 reset state
        check(rdata, 32'h0, "R8 rdata in reset");
        check({31'h0, irq}, 32'h0, "R8 irq in reset");
        rst_n = 1'b1;
        tick();
        check(rdata, 32'h0, "R8 rdata after reset");

        for (int i = 0; i < 15; i++) begin
            wen = VECS[i].wr;
            wdata = VECS[i].data;
            evt = VECS[i].ev;
            tick();
            check(rdata, VECS[i].exp_rd, $sformatf("R%0d vec %0d rdata", VECS[i].req, i));
            check({31'h0, irq}, {31'h0, VECS[i].exp_irq},
                  $sformatf("R%0d vec %0d irq", VECS[i].req, i));
        end
        wen = 1'b0;
        wdata = '0;

        // R10: held line sets once
        evt = 7'h04;
        tick();
        check(rdata, 32'h0004_0000, "R10 held line captured");
        wen = 1'b1; wdata = 32'h0004_0000;
        tick();
        wen = 1'b0; wdata = '0;
        check(rdata, 32'h0, "R10 cleared");
        tick();
        tick();
        check(rdata, 32'h0, "R10 no recapture while held");
        evt = 7'h00;
        tick();

        // R6: two pending, clear one at a time
        evt = 7'h03;
        tick();
        evt = 7'h00;
        wen = 1'b1; wdata = 32'h0000_0003;
        tick();
        wen = 1'b0;
        tick();
        check({31'h0, irq}, 32'h1, "R6 two pending raise");
        wen = 1'b1; wdata = 32'h0001_0003;
        tick();
        wen = 1'b0;
        tick();
        check({31'h0, irq}, 32'h1, "R6 one left still raised");
        check(rdata, 32'h0002_0003, "R6 remaining status");
        wen = 1'b1; wdata = 32'h0002_0003;
        tick();
        wen = 1'b0;
        tick();
        check({31'h0, irq}, 32'h0, "R6 all cleared drops");

        // R9: init sequence
        evt = 7'h10;
        tick();
        wen = 1'b1; wdata = 32'h0000_007F;
        tick();
        wen = 1'b0;
        tick();
        check({31'h0, irq}, 32'h1, "R9 pending before init");
        wen = 1'b1; wdata = 32'hFFFF_0000;
        tick();
        wdata = 32'h0000_0000;
        tick();
        wen = 1'b0;
        tick();
        check(rdata, 32'h0, "R9 register empty after init");
        check({31'h0, irq}, 32'h0, "R9 irq low after init");
        evt = 7'h00;
        tick();

        // R8: reset in mid-run
        evt = 7'h01;
        wen = 1'b1; wdata = 32'h0000_0001;
        tick();
        wen = 1'b0;
        tick();
        check({31'h0, irq}, 32'h1, "R8 busy before reset");
        rst_n = 1'b0;
        #2;
        check(rdata, 32'h0, "R8 rdata mid-run reset");
        check({31'h0, irq}, 32'h0, "R8 irq mid-run reset");
        evt = 7'h00;
        tick();
        rst_n = 1'b1;
        tick();

        // R1: placement with two sources at bit 4
        alt_wen = 1'b1; alt_wdata = 32'hFFFF_FFFF;
        tick();
        alt_wen = 1'b0; alt_wdata = '0;
        check(alt_rdata, 32'h0000_0030, "R1 alt enable placement");
        alt_evt = 2'b01;
        tick();
        check(alt_rdata, 32'h0010_0030, "R1 alt status placement");
        tick();
        check({31'h0, alt_irq}, 32'h1, "R1 alt irq");
        alt_evt = 2'b10;
        tick();
        check(alt_rdata, 32'h0030_0030, "R1 alt second source");

        finish_run();
    end

endmodule